// File: doc/BRIEF.md
# Time-Shared Two-Product Expression Unit

This block evaluates two results from five unsigned operands: `f = e * (a + b)` and `g = (a + b) * (c + d)`. It uses only one adder and one multiplier. The shared sum `a + b` is formed once and feeds both products. Four working registers hold operands and partial results. Each register has a small source multiplexer, so it can capture either a block input or the output of one of the two arithmetic units.

A microcoded sequencer drives the datapath. The state register addresses a small ROM. Each ROM entry carries an 8-bit control word and a 4-bit next-state address. The control word holds four register load enables, an input-fetch flag, a phase flag that steers the multiplexers, a done flag and a wait-for-start flag.

The states run in this order:
- `ST_IDLE` waits for `start`.
- `ST_FETCH_AB` captures `a` and `b`.
- `ST_FETCH_CDE` adds `a + b` while capturing `c`, `d` and `e`.
- `ST_SUM_MUL` adds `c + d` while multiplying the shared sum by `e`.
- `ST_MUL` forms the second product.
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

The transitions are:
- `ST_IDLE` moves to `ST_FETCH_AB` on `start` and otherwise holds.
- Every other state advances unconditionally to the next-state address in its ROM entry.

A user raises `start` for one cycle and holds the operands stable for the next two cycles. The user then reads `f_out` and `g_out` while `done` is high, or at any later time before the next run.

Top module: `exprunit_top`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `f_out` and `g_out` are 0 and the sequencer sits in `ST_IDLE`.
- R2: At `done`, `f_out` equals the low 8 bits of `e * ((a + b) mod 256)`.
- R3: At `done`, `g_out` equals the low 8 bits of `((a + b) mod 256) * ((c + d) mod 256)`.
- R4: `start` sampled high in `ST_IDLE` at clock edge k moves the sequencer to `ST_FETCH_AB`. `done` is then high for exactly one cycle, the cycle after edge k+4.
- R5: `start` is ignored in every state other than `ST_IDLE`. A start seen during a run neither restarts the run nor produces a second `done` pulse.
- R6: `a` and `b` are sampled at edge k+1, and `c`, `d` and `e` at edge k+2. Input changes after edge k+2 do not alter the results of that run.
- R7: `f_out` and `g_out` hold their values while the sequencer idles after `done`, whatever the operand inputs do.
- R8: After `done` the sequencer is back in `ST_IDLE`, and a following `start` begins a new run that yields correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when sampled high in the idle state |
| op_a | input | 8 | Operand a |
| op_b | input | 8 | Operand b |
| op_c | input | 8 | Operand c |
| op_d | input | 8 | Operand d |
| op_e | input | 8 | Operand e |
| f_out | output | 8 | Result e*(a+b), low 8 bits |
| g_out | output | 8 | Result (a+b)*(c+d), low 8 bits |
| done | output | 1 | One-cycle pulse marking valid results |

## Verification
The operand table covers several cases:
- sums that wrap past 255 (a+b = 300, c+d = 260) and a sum that wraps exactly to zero;
- a product whose low byte is zero;
- all operands at 255.

A multiplexer that picked the wrong register, or products that were not truncated, would give the wrong `f_out` or `g_out` on these vectors. Two directed runs deal with timing and control:
- One scrambles every operand just after the last fetch edge. A sequencer that sampled inputs late would show the scrambled values.
- One raises `start` mid-run. A controller that restarted would show a delayed or repeated `done`.

An idle window with changing inputs exposes any register that loads outside its scheduled state.

// File: rtl/exprunit_pkg.sv
package exprunit_pkg;

    // Sequencer states; the encoding doubles as the microcode ROM address.
    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_FETCH_AB  = 4'd1,
        ST_FETCH_CDE = 4'd2,
        ST_SUM_MUL   = 4'd3,
        ST_MUL       = 4'd4,
        ST_DONE      = 4'd5
    } state_e;

    // 8-bit control word. ld[i] loads working register i (R1..R4 -> 0..3).
    typedef struct packed {
        logic       hold_for_start;
        logic       done;
        logic       fetch;
        logic       phase;
        logic [3:0] ld;
    } ctrl_t;

    // One ROM entry: control word followed by a 4-bit next address.
    typedef struct packed {
        ctrl_t  ctrl;
        state_e next;
    } uword_t;

endpackage

// File: rtl/exprunit_rom.sv
module exprunit_rom
    import exprunit_pkg::*;
(
    input  state_e addr,
    output uword_t word
);

    always_comb begin
        word = '{ctrl: '0, next: ST_IDLE};
        unique case (addr)
            ST_IDLE: begin
                word.ctrl.hold_for_start = 1'b1;
                word.next                = ST_FETCH_AB;
            end
            ST_FETCH_AB: begin
                word.ctrl.fetch = 1'b1;
                word.ctrl.phase = 1'b0;
                word.ctrl.ld    = 4'b1100;   // R3 <- a, R4 <- b
                word.next       = ST_FETCH_CDE;
            end
            ST_FETCH_CDE: begin
                word.ctrl.fetch = 1'b1;
                word.ctrl.phase = 1'b1;
                word.ctrl.ld    = 4'b1111;   // R1 <- e, R2 <- a+b, R3 <- c, R4 <- d
                word.next       = ST_SUM_MUL;
            end
            ST_SUM_MUL: begin
                word.ctrl.fetch = 1'b0;
                word.ctrl.phase = 1'b0;
                word.ctrl.ld    = 4'b0101;   // R1 <- R2*R1, R3 <- R3+R4
                word.next       = ST_MUL;
            end
            ST_MUL: begin
                word.ctrl.fetch = 1'b0;
                word.ctrl.phase = 1'b1;
                word.ctrl.ld    = 4'b0010;   // R2 <- R2*R3
                word.next       = ST_DONE;
            end
            ST_DONE: begin
                word.ctrl.done = 1'b1;
                word.next      = ST_IDLE;
            end
            default: begin
                word.next = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/exprunit_sequencer.sv
module exprunit_sequencer
    import exprunit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   hold_for_start,
    input  state_e next_addr,
    output state_e state_q
);

    state_e state_d;

    // Next-state selection: only a wait-for-start entry can stall.
    always_comb begin
        if (hold_for_start && !start) begin
            state_d = state_q;
        end else begin
            state_d = next_addr;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/exprunit_datapath.sv
module exprunit_datapath #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic              phase,
    input  logic [NREG-1:0]   ld,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic [DATA_W-1:0] op_d,
    input  logic [DATA_W-1:0] op_e,
    output logic [DATA_W-1:0] res_f,
    output logic [DATA_W-1:0] res_g
);

    logic [DATA_W-1:0] rq   [NREG];
    logic [DATA_W-1:0] rsrc [NREG];
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] mul_b;
    logic [DATA_W-1:0] prod;

    // The single adder always sums R3 and R4.
    assign sum   = rq[2] + rq[3];
    // The single multiplier takes R2 times R1 or R3, chosen by phase.
    assign mul_b = phase ? rq[2] : rq[0];
    assign prod  = rq[1] * mul_b;

    // Per-register source multiplexers.
    always_comb begin
        rsrc[0] = fetch ? op_e : prod;
        rsrc[1] = fetch ? sum  : prod;
        rsrc[2] = fetch ? (phase ? op_c : op_a) : sum;
        rsrc[3] = phase ? op_d : op_b;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rq[i] <= '0;
            end else if (ld[i]) begin
                rq[i] <= rsrc[i];
            end
        end
    end

    assign res_f = rq[0];
    assign res_g = rq[1];

endmodule

// File: rtl/exprunit_top.sv
module exprunit_top
    import exprunit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic [DATA_W-1:0] op_d,
    input  logic [DATA_W-1:0] op_e,
    output logic [DATA_W-1:0] f_out,
    output logic [DATA_W-1:0] g_out,
    output logic              done
);

    localparam int NREG = 4;

    state_e state_q;
    uword_t uword;

    exprunit_rom i_rom (
        .addr (state_q),
        .word (uword)
    );

    exprunit_sequencer i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .hold_for_start (uword.ctrl.hold_for_start),
        .next_addr      (uword.next),
        .state_q        (state_q)
    );

    exprunit_datapath #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) i_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .fetch (uword.ctrl.fetch),
        .phase (uword.ctrl.phase),
        .ld    (uword.ctrl.ld),
        .op_a  (op_a),
        .op_b  (op_b),
        .op_c  (op_c),
        .op_d  (op_d),
        .op_e  (op_e),
        .res_f (f_out),
        .res_g (g_out)
    );

    assign done = uword.ctrl.done;

endmodule

// File: rtl/exprunit_checker.sv
module exprunit_checker
    import exprunit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] f_out,
    input logic [DATA_W-1:0] g_out,
    input state_e            state_q
);

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_FETCH_AB)); // R4

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_FETCH_AB)); // R5

    AST_IDLE_HOLDS_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(f_out) && $stable(g_out))); // R7

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE)); // R8

endmodule

bind exprunit_top exprunit_checker #(.DATA_W(DATA_W)) i_exprunit_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .f_out   (f_out),
    .g_out   (g_out),
    .state_q (state_q)
);

// File: tb/test_exprunit_top.sv
module test_exprunit_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0, op_e = '0;
    logic [7:0] f_out, g_out;
    logic       done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    exprunit_top i_exprunit_top (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op_a  (op_a),
        .op_b  (op_b),
        .op_c  (op_c),
        .op_d  (op_d),
        .op_e  (op_e),
        .f_out (f_out),
        .g_out (g_out),
        .done  (done)
    );

    // Operand table {a, b, c, d, e}.
    localparam logic [39:0] VEC [8] = '{
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
        {8'd1,   8'd2,   8'd3,   8'd4,   8'd5},
        {8'd200, 8'd100, 8'd30,  8'd40,  8'd7},
        {8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        {8'd16,  8'd16,  8'd16,  8'd16,  8'd16},
        {8'd10,  8'd20,  8'd250, 8'd10,  8'd3},
        {8'd3,   8'd5,   8'd7,   8'd11,  8'd13},
        {8'd128, 8'd128, 8'd1,   8'd1,   8'd9}
    };

    function automatic logic [7:0] model_f(logic [7:0] a, logic [7:0] b, logic [7:0] e);
        logic [7:0] s;
        s = a + b;
        return 8'(s * e);
    endfunction

    function automatic logic [7:0] model_g(logic [7:0] a, logic [7:0] b,
                                           logic [7:0] c, logic [7:0] d);
        logic [7:0] s, t;
        s = a + b;
        t = c + d;
        return 8'(s * t);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One run. lat counts falling edges after the start edge until done.
    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input logic [7:0] d, input logic [7:0] e,
                          input bit scramble, input bit poke,
                          output logic [7:0] f_o, output logic [7:0] g_o,
                          output int lat, output logic done_after);
        int n;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d; op_e = e;
        start = 1'b1;
        n = 0;
        lat = -1;
        while (lat < 0 && n < 20) begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (poke && n == 2) start = 1'b1;
            if (poke && n == 3) start = 1'b0;
            if (scramble && n == 3) begin
                op_a = ~a; op_b = ~b; op_c = ~c; op_d = ~d; op_e = ~e;
            end
            if (done) lat = n;
        end
        f_o = f_out;
        g_o = g_out;
        @(negedge clk);
        done_after = done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 100000 expected 0 (cycles)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rf, rg, hf, hg;
        int         lat;
        logic       dn;
        int         quiet;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(f_out == 8'd0, "R1", "f in reset", int'(f_out), 0);
        check(g_out == 8'd0, "R1", "g in reset", int'(g_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);

        // Table walk: R2, R3, R4, R8 (back-to-back runs)
        for (int i = 0; i < 8; i++) begin
            run_op(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                   1'b0, 1'b0, rf, rg, lat, dn);
            check(rf == model_f(VEC[i][39:32], VEC[i][31:24], VEC[i][7:0]),
                  "R2", $sformatf("f vec %0d", i), int'(rf),
                  int'(model_f(VEC[i][39:32], VEC[i][31:24], VEC[i][7:0])));
            check(rg == model_g(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]),
                  "R3", $sformatf("g vec %0d", i), int'(rg),
                  int'(model_g(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8])));
            check(lat == 5, "R4", $sformatf("latency vec %0d", i), lat, 5);
            check(dn == 1'b0, "R4", $sformatf("done width vec %0d", i), int'(dn), 0);
            if (i > 0) begin
                check(lat == 5, "R8", $sformatf("restart after done vec %0d", i), lat, 5);
            end
        end

        // R6: operands scrambled after the last fetch edge
        run_op(8'd77, 8'd99, 8'd5, 8'd6, 8'd11, 1'b1, 1'b0, rf, rg, lat, dn);
        check(rf == model_f(8'd77, 8'd99, 8'd11), "R6", "f with late input change",
              int'(rf), int'(model_f(8'd77, 8'd99, 8'd11)));
        check(rg == model_g(8'd77, 8'd99, 8'd5, 8'd6), "R6", "g with late input change",
              int'(rg), int'(model_g(8'd77, 8'd99, 8'd5, 8'd6)));

        // R5: start raised mid-run
        run_op(8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 1'b0, 1'b1, rf, rg, lat, dn);
        check(lat == 5, "R5", "latency with mid-run start", lat, 5);
        check(rf == model_f(8'd9, 8'd8, 8'd5), "R5", "f with mid-run start",
              int'(rf), int'(model_f(8'd9, 8'd8, 8'd5)));
        check(rg == model_g(8'd9, 8'd8, 8'd7, 8'd6), "R5", "g with mid-run start",
              int'(rg), int'(model_g(8'd9, 8'd8, 8'd7, 8'd6)));
        quiet = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) quiet++;
        end
        check(quiet == 0 && dn == 1'b0, "R5", "extra done pulses", quiet, 0);

        // R7: results held while idle with moving inputs
        hf = f_out;
        hg = g_out;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            op_a = 8'(k * 37); op_b = 8'(k * 11); op_c = 8'(k + 90);
            op_d = 8'(255 - k); op_e = 8'(k * 3);
        end
        check(f_out == hf, "R7", "f held in idle", int'(f_out), int'(hf));
        check(g_out == hg, "R7", "g held in idle", int'(g_out), int'(hg));
        check(done == 1'b0, "R7", "no done in idle", int'(done), 0);

        // R8: a fresh run after the idle window
        run_op(8'd250, 8'd10, 8'd128, 8'd128, 8'd2, 1'b0, 1'b0, rf, rg, lat, dn);
        check(rf == model_f(8'd250, 8'd10, 8'd2), "R8", "f after idle window",
              int'(rf), int'(model_f(8'd250, 8'd10, 8'd2)));
        check(rg == model_g(8'd250, 8'd10, 8'd128, 8'd128), "R8", "g after idle window",
              int'(rg), int'(model_g(8'd250, 8'd10, 8'd128, 8'd128)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule